// File: doc/BRIEF.md
# Shifted Second-Operand Generator

This block forms the second operand of a 32-bit data-processing datapath together with the carry-out of the shifter. The operand comes from one of two sources. The first is a small constant: an 8-bit value rotated inside the word by an even amount. The second is a register value, which may pass through unchanged, be shifted left or right, be shifted right arithmetically, be rotated right, or be rotated right by one place through the carry flag. The shift count comes either from a 5-bit field of the instruction or from the low byte of a second register.

The carry-out goes to the flag logic, which uses it as the new carry flag for logical and move operations. When nothing is shifted out, the carry-out repeats the incoming carry flag. Both results are registered, so they appear one clock after the inputs that produced them.

Top module: `operand_shifter`

## Requirements
- R1: While reset is asserted, and after it, until the first clock with reset released, `operand` reads 0 and `carry_out` reads 0. In normal operation both outputs reflect the inputs sampled at the previous rising clock edge.
- R2: With `imm_sel`=1, `operand` is `imm_val` zero-extended to 32 bits and rotated right by twice `imm_rot`. For a nonzero rotation, `carry_out` equals bit 31 of that operand.
- R3: With `imm_sel`=1 and `imm_rot`=0, `carry_out` equals `carry_in`.
- R4: `shift_kind` is encoded as 00 shift left, 01 logical shift right, 10 arithmetic shift right and 11 rotate right. The count is `cnt_imm` when `cnt_from_reg`=0 and `rs_val[7:0]` when `cnt_from_reg`=1. Bits 31..8 of `rs_val` have no effect on either output.
- R5: For a register operand with a count of zero, `operand` equals `rm_val` and `carry_out` equals `carry_in`. The exception is the one-place rotate selection of R10.
- R6: For a left or logical-right shift by n in 1..31, vacated bits are 0. `carry_out` is the last bit shifted out: `rm_val[32-n]` for a left shift and `rm_val[n-1]` for a right shift.
- R7: For a left or logical-right shift by exactly 32, `operand` is 0 and `carry_out` is `rm_val[0]` (left) or `rm_val[31]` (right). For counts above 32, both outputs are 0.
- R8: An arithmetic right shift by n in 1..31 fills the vacated bits with `rm_val[31]`, and `carry_out` is `rm_val[n-1]`. For n of 32 or more, every bit of `operand` and `carry_out` equal `rm_val[31]`.
- R9: A rotate right by a nonzero count n rotates by n modulo 32, and `carry_out` equals bit 31 of the resulting `operand`. A nonzero multiple of 32 leaves the value unchanged and gives `carry_out` = `rm_val[31]`.
- R10: With `shift_kind`=11, `cnt_from_reg`=0 and `cnt_imm`=0, `operand` is {`carry_in`, `rm_val[31:1]`} and `carry_out` is `rm_val[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imm_sel | input | 1 | 1 selects the rotated constant, 0 selects the register path |
| imm_val | input | 8 | Constant before rotation |
| imm_rot | input | 4 | Rotation code; the rotation amount is twice this value |
| rm_val | input | 32 | Register value to shift |
| shift_kind | input | 2 | Shift type (see R4) |
| cnt_from_reg | input | 1 | 1 takes the count from `rs_val[7:0]`, 0 takes it from `cnt_imm` |
| cnt_imm | input | 5 | Instruction-field shift count |
| rs_val | input | 32 | Register holding the shift count |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Registered second operand |
| carry_out | output | 1 | Registered shifter carry-out |

## Verification
The bench aims at count boundaries: 0, 1, 31, 32, 33 and large register counts for every shift type. A design that saturates at the wrong count would return a stale carry at 32 or leave a nonzero result above it. An arithmetic shift that does not saturate would give zeros instead of sign copies. Register counts carry random upper bits so that a decoder reading more than the low byte would shift wrongly. Constants are swept through all rotation codes with patterns that straddle bit 0, which exposes a rotation by the raw code instead of twice the code. The one-place rotate is run with both carry values, because a block that dropped the old carry into bit 31 would differ only there.

// File: rtl/opsh_pkg.sv
package opsh_pkg;

   typedef enum logic [1:0] {
      SH_LSL = 2'b00,
      SH_LSR = 2'b01,
      SH_ASR = 2'b10,
      SH_ROR = 2'b11
   } shift_kind_e;

endpackage

// File: rtl/opsh_imm_rotator.sv
module opsh_imm_rotator #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8,
   parameter int ROT_W  = 4
) (
   input  logic [IMM_W-1:0]  imm,
   input  logic [ROT_W-1:0]  rot,
   input  logic              carry_in,
   output logic [DATA_W-1:0] value,
   output logic              carry_out
);
   localparam int SHW = $clog2(DATA_W);

   logic [DATA_W-1:0] base;
   logic [SHW-1:0]    amt;

   always_comb begin
      base  = DATA_W'(imm);
      amt   = SHW'({rot, 1'b0});
      value = (base >> amt) | (base << (DATA_W - int'(amt)));
      carry_out = (rot == '0) ? carry_in : value[DATA_W-1];
   end

endmodule

// File: rtl/opsh_reg_shifter.sv
module opsh_reg_shifter
   import opsh_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 8
) (
   input  logic [DATA_W-1:0] value,
   input  shift_kind_e       kind,
   input  logic [CNT_W-1:0]  count,
   input  logic              rrx,
   input  logic              carry_in,
   output logic [DATA_W-1:0] result,
   output logic              carry_out
);
   localparam int SHW = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] SAT_CNT = CNT_W'(DATA_W);

   logic [DATA_W:0]        wide_l;
   logic [DATA_W:0]        wide_r;
   logic signed [DATA_W:0] wide_a;
   logic [CNT_W-1:0]       asr_cnt;
   logic [SHW-1:0]         rot_amt;

   always_comb begin
      wide_l    = {1'b0, value} << count;
      wide_r    = {value, 1'b0} >> count;
      asr_cnt   = (count > SAT_CNT) ? SAT_CNT : count;
      wide_a    = $signed({value, 1'b0}) >>> asr_cnt;
      rot_amt   = count[SHW-1:0];
      result    = value;
      carry_out = carry_in;
      if (rrx) begin
         result    = {carry_in, value[DATA_W-1:1]};
         carry_out = value[0];
      end else if (count != '0) begin
         case (kind)
            SH_LSL: begin
               result    = wide_l[DATA_W-1:0];
               carry_out = wide_l[DATA_W];
            end
            SH_LSR: begin
               result    = wide_r[DATA_W:1];
               carry_out = wide_r[0];
            end
            SH_ASR: begin
               result    = wide_a[DATA_W:1];
               carry_out = wide_a[0];
            end
            default: begin
               result    = (value >> rot_amt) | (value << (DATA_W - int'(rot_amt)));
               carry_out = result[DATA_W-1];
            end
         endcase
      end
   end

endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
   import opsh_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int IMM_W     = 8,
   parameter int ROT_W     = 4,
   parameter int IMM_CNT_W = 5,
   parameter int CNT_W     = 8,
   parameter bit REG_OUT   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 imm_sel,
   input  logic [IMM_W-1:0]     imm_val,
   input  logic [ROT_W-1:0]     imm_rot,
   input  logic [DATA_W-1:0]    rm_val,
   input  logic [1:0]           shift_kind,
   input  logic                 cnt_from_reg,
   input  logic [IMM_CNT_W-1:0] cnt_imm,
   input  logic [DATA_W-1:0]    rs_val,
   input  logic                 carry_in,
   output logic [DATA_W-1:0]    operand,
   output logic                 carry_out
);
   localparam int SHW = $clog2(DATA_W);

   if (DATA_W != (1 << SHW)) begin : g_chk_width
      $error("DATA_W must be a power of two");
   end
   if (IMM_W > DATA_W) begin : g_chk_imm
      $error("IMM_W must not exceed DATA_W");
   end
   if (2 * ((1 << ROT_W) - 1) >= DATA_W) begin : g_chk_rot
      $error("rotation range must stay below DATA_W");
   end
   if ((1 << CNT_W) <= DATA_W || CNT_W >= DATA_W) begin : g_chk_cnt
      $error("CNT_W must reach DATA_W and fit in a register");
   end
   if (IMM_CNT_W != SHW) begin : g_chk_icnt
      $error("IMM_CNT_W must equal log2(DATA_W)");
   end

   shift_kind_e       kind;
   logic [CNT_W-1:0]  count;
   logic              rrx;
   logic [DATA_W-1:0] imm_res, reg_res, nxt_op;
   logic              imm_c, reg_c, nxt_c;
   logic              unused_rs_hi;

   assign kind         = shift_kind_e'(shift_kind);
   assign count        = cnt_from_reg ? rs_val[CNT_W-1:0] : CNT_W'(cnt_imm);
   assign rrx          = (kind == SH_ROR) && !cnt_from_reg && (cnt_imm == '0);
   assign unused_rs_hi = ^rs_val[DATA_W-1:CNT_W];

   opsh_imm_rotator #(
      .DATA_W (DATA_W),
      .IMM_W  (IMM_W),
      .ROT_W  (ROT_W)
   ) u_imm (
      .imm       (imm_val),
      .rot       (imm_rot),
      .carry_in  (carry_in),
      .value     (imm_res),
      .carry_out (imm_c)
   );

   opsh_reg_shifter #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_reg (
      .value     (rm_val),
      .kind      (kind),
      .count     (count),
      .rrx       (rrx),
      .carry_in  (carry_in),
      .result    (reg_res),
      .carry_out (reg_c)
   );

   assign nxt_op = imm_sel ? imm_res : reg_res;
   assign nxt_c  = imm_sel ? imm_c   : reg_c;

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            operand   <= '0;
            carry_out <= 1'b0;
         end else begin
            operand   <= nxt_op;
            carry_out <= nxt_c;
         end
      end
   end else begin : g_comb_out
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign operand    = nxt_op;
      assign carry_out  = nxt_c;
   end

endmodule

// File: rtl/operand_shifter_checker.sv
module operand_shifter_checker #(
   parameter int DATA_W    = 32,
   parameter int IMM_W     = 8,
   parameter int ROT_W     = 4,
   parameter int IMM_CNT_W = 5,
   parameter int CNT_W     = 8,
   parameter bit REG_OUT   = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 imm_sel,
   input logic [IMM_W-1:0]     imm_val,
   input logic [ROT_W-1:0]     imm_rot,
   input logic [DATA_W-1:0]    rm_val,
   input logic [1:0]           shift_kind,
   input logic                 cnt_from_reg,
   input logic [IMM_CNT_W-1:0] cnt_imm,
   input logic [DATA_W-1:0]    rs_val,
   input logic                 carry_in,
   input logic [DATA_W-1:0]    operand,
   input logic                 carry_out
);
   logic [CNT_W-1:0] rcnt;
   logic             unused_rs_hi;
   logic             nz_count;
   assign rcnt         = rs_val[CNT_W-1:0];
   assign unused_rs_hi = ^rs_val[DATA_W-1:CNT_W];
   assign nz_count     = cnt_from_reg ? (rcnt != '0) : (cnt_imm != '0);

   if (REG_OUT) begin : g_props
      a_r1_reset_clear: assert property (@(posedge clk)
         !rst_n |=> (operand == '0 && !carry_out));

      a_r3_imm_unrotated: assert property (@(posedge clk) disable iff (!rst_n)
         (imm_sel && imm_rot == '0) |=>
            (operand == DATA_W'($past(imm_val)) && carry_out == $past(carry_in)));

      a_r5_zero_reg_count: assert property (@(posedge clk) disable iff (!rst_n)
         (!imm_sel && cnt_from_reg && rcnt == '0) |=>
            (operand == $past(rm_val) && carry_out == $past(carry_in)));

      a_r7_lsl_beyond: assert property (@(posedge clk) disable iff (!rst_n)
         (!imm_sel && shift_kind == 2'b00 && cnt_from_reg && rcnt > CNT_W'(DATA_W)) |=>
            (operand == '0 && !carry_out));

      a_r8_asr_saturate: assert property (@(posedge clk) disable iff (!rst_n)
         (!imm_sel && shift_kind == 2'b10 && cnt_from_reg && rcnt >= CNT_W'(DATA_W)) |=>
            (operand == {DATA_W{$past(rm_val[DATA_W-1])}} &&
             carry_out == $past(rm_val[DATA_W-1])));

      a_r9_ror_carry_msb: assert property (@(posedge clk) disable iff (!rst_n)
         (!imm_sel && shift_kind == 2'b11 && nz_count) |=>
            (carry_out == operand[DATA_W-1]));

      a_r10_rrx: assert property (@(posedge clk) disable iff (!rst_n)
         (!imm_sel && shift_kind == 2'b11 && !cnt_from_reg && cnt_imm == '0) |=>
            (operand == {$past(carry_in), $past(rm_val[DATA_W-1:1])} &&
             carry_out == $past(rm_val[0])));
   end

endmodule

bind operand_shifter operand_shifter_checker #(
   .DATA_W    (DATA_W),
   .IMM_W     (IMM_W),
   .ROT_W     (ROT_W),
   .IMM_CNT_W (IMM_CNT_W),
   .CNT_W     (CNT_W),
   .REG_OUT   (REG_OUT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .imm_sel      (imm_sel),
   .imm_val      (imm_val),
   .imm_rot      (imm_rot),
   .rm_val       (rm_val),
   .shift_kind   (shift_kind),
   .cnt_from_reg (cnt_from_reg),
   .cnt_imm      (cnt_imm),
   .rs_val       (rs_val),
   .carry_in     (carry_in),
   .operand      (operand),
   .carry_out    (carry_out)
);

// File: tb/operand_shifter_bench.sv
`timescale 1ns/1ps
module operand_shifter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        imm_sel = 1'b0;
   logic [7:0]  imm_val = '0;
   logic [3:0]  imm_rot = '0;
   logic [31:0] rm_val = '0;
   logic [1:0]  shift_kind = '0;
   logic        cnt_from_reg = 1'b0;
   logic [4:0]  cnt_imm = '0;
   logic [31:0] rs_val = '0;
   logic        carry_in = 1'b0;
   logic [31:0] operand;
   logic        carry_out;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  finished = 1'b0;

   always #4 clk = ~clk;

   operand_shifter u_operand_shifter (
      .clk(clk), .rst_n(rst_n), .imm_sel(imm_sel), .imm_val(imm_val),
      .imm_rot(imm_rot), .rm_val(rm_val), .shift_kind(shift_kind),
      .cnt_from_reg(cnt_from_reg), .cnt_imm(cnt_imm), .rs_val(rs_val),
      .carry_in(carry_in), .operand(operand), .carry_out(carry_out)
   );

   // bit-at-a-time reference model: {carry, operand}
   function automatic logic [32:0] model();
      logic [31:0] v;
      logic        c;
      int          n;
      c = carry_in;
      if (imm_sel) begin
         v = {24'b0, imm_val};
         for (int k = 0; k < 2 * int'(imm_rot); k++) begin
            c = v[0];
            v = {v[0], v[31:1]};
         end
         return {c, v};
      end
      v = rm_val;
      if (shift_kind == 2'b11 && !cnt_from_reg && cnt_imm == 5'd0)
         return {v[0], c, v[31:1]};
      n = cnt_from_reg ? int'(rs_val[7:0]) : int'(cnt_imm);
      for (int k = 0; k < n; k++) begin
         case (shift_kind)
            2'b00: begin c = v[31]; v = {v[30:0], 1'b0}; end
            2'b01: begin c = v[0];  v = {1'b0, v[31:1]}; end
            2'b10: begin c = v[0];  v = {v[31], v[31:1]}; end
            default: begin c = v[0]; v = {v[0], v[31:1]}; end
         endcase
      end
      return {c, v};
   endfunction

   function automatic string req_tag();
      int n;
      if (imm_sel) return (imm_rot == 4'd0) ? "R3" : "R2";
      if (shift_kind == 2'b11 && !cnt_from_reg && cnt_imm == 5'd0) return "R10";
      n = cnt_from_reg ? int'(rs_val[7:0]) : int'(cnt_imm);
      if (n == 0) return "R5";
      case (shift_kind)
         2'b00, 2'b01: return (n < 32) ? "R6" : "R7";
         2'b10: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   // inputs are already set; one edge later the registered result is sampled
   task automatic step_check(input string force_tag);
      logic [32:0] exp;
      string       tag;
      exp = model();
      tag = (force_tag != "") ? force_tag : req_tag();
      @(negedge clk);
      n_checks++;
      if ({carry_out, operand} !== exp) begin
         n_errors++;
         $display("FAIL %s: actual carry=%0b op=%08h expected carry=%0b op=%08h",
                  tag, carry_out, operand, exp[32], exp[31:0]);
      end
   endtask

   task automatic drive_reg(input logic [31:0] rm, input logic [1:0] kind,
                            input logic from_reg, input logic [4:0] ci,
                            input logic [31:0] rs, input logic cin);
      imm_sel = 1'b0; rm_val = rm; shift_kind = kind; cnt_from_reg = from_reg;
      cnt_imm = ci; rs_val = rs; carry_in = cin;
      imm_val = 8'($urandom); imm_rot = 4'($urandom);
   endtask

   initial begin
      #(8 * 150000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int amts[7] = '{0, 1, 31, 32, 33, 200, 255};
      logic [31:0] pats[3] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hC35A_0F96};
      void'($urandom(32'd5150));

      // R1: reset holds outputs at zero even with live inputs
      imm_sel = 1'b1; imm_val = 8'hFF; carry_in = 1'b1;
      repeat (3) @(negedge clk);
      n_checks++;
      if (operand !== 32'h0 || carry_out !== 1'b0) begin
         n_errors++;
         $display("FAIL R1: actual carry=%0b op=%08h expected carry=0 op=00000000",
                  carry_out, operand);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R2/R3: every rotation code
      for (int r = 0; r < 16; r++) begin
         for (int p = 0; p < 2; p++) begin
            imm_sel = 1'b1; imm_rot = 4'(r); imm_val = p ? 8'hA5 : 8'h81;
            carry_in = p[0];
            step_check("");
         end
      end

      // R5..R9: register-count boundaries for each shift type
      for (int k = 0; k < 4; k++)
         for (int a = 0; a < 7; a++)
            for (int p = 0; p < 3; p++) begin
               drive_reg(pats[p], 2'(k), 1'b1, 5'($urandom),
                         {24'($urandom), 8'(amts[a])}, 1'(p));
               step_check("");
            end

      // immediate-field counts 0, 1, 31
      for (int k = 0; k < 4; k++)
         for (int p = 0; p < 3; p++) begin
            drive_reg(pats[p], 2'(k), 1'b0, 5'd1, $urandom, 1'b1);  step_check("");
            drive_reg(pats[p], 2'(k), 1'b0, 5'd31, $urandom, 1'b0); step_check("");
            drive_reg(pats[p], 2'(k), 1'b0, 5'd0, $urandom, 1'(p)); step_check("");
         end

      // R10: one-place rotate with both carry values
      drive_reg(32'h0000_0003, 2'b11, 1'b0, 5'd0, 32'h0, 1'b0); step_check("R10");
      drive_reg(32'h0000_0002, 2'b11, 1'b0, 5'd0, 32'h0, 1'b1); step_check("R10");

      // R4: upper count bits are ignored; count from reg vs field
      drive_reg(32'h1234_5678, 2'b00, 1'b1, 5'd7, 32'hABCD_EF00, 1'b1); step_check("R4");
      drive_reg(32'h1234_5678, 2'b01, 1'b1, 5'd0, 32'hFFFF_FF04, 1'b0); step_check("R4");
      drive_reg(32'h1234_5678, 2'b01, 1'b0, 5'd4, 32'hFFFF_FF09, 1'b0); step_check("R4");

      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] cb;
         case ($urandom % 8)
            0: cb = 8'd0;
            1: cb = 8'd1;
            2: cb = 8'd31;
            3: cb = 8'd32;
            4: cb = 8'(33 + ($urandom % 223));
            default: cb = 8'($urandom);
         endcase
         drive_reg($urandom, 2'($urandom), 1'($urandom),
                   ($urandom % 4 == 0) ? 5'd0 : 5'($urandom),
                   {24'($urandom), cb}, 1'($urandom));
         imm_sel = ($urandom % 4 == 0);
         step_check("");
      end

      finish_run();
   end

endmodule